// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Controller

This block converts single internal read or write requests into cycles on an external bus whose sixteen pins carry first the address and then the data. Each bus cycle opens with one clock of address, marked by an address latch strobe. A data phase follows in which either a read strobe or one or both of two byte-lane write strobes are active. The data phase lasts one clock plus a wait count. The wait count is programmed separately for each of four memory areas, and the two highest address bits select the area.

The internal side presents an address, write data, two byte enables, a direction bit and a width selector, and waits for a single-cycle acknowledge that carries any read data. With the narrow (8-bit) width selected, the external data travels on the low byte lane only. A request that enables both bytes then becomes two back-to-back bus cycles: the even byte first, then the odd byte. Byte placement is little-endian, so the even address maps to bits 7:0.

Top module: `mxbus_ctrl`

## Requirements
- R1: While reset is held and right after it, `ale` is 0, `rd_n` and both `wr_n` bits are 1, `ad_oe` is 0, `req_ack` is 0 and `req_ready` is 1.
- R2: A bus cycle is one clock with `ale`=1 and the beat address driven on `ad_out` with `ad_oe`=1, followed directly by the strobe phase. With zero waits the whole cycle is 2 clocks. `req_ack` rises in the clock after the last strobe clock, which is the 3rd clock after acceptance for a single-beat access.
- R3: The wait count is taken from the register of area `req_addr[15:14]` at acceptance, and the strobe phase lasts 1 + wait clocks. `cfg_we` with `cfg_area`/`cfg_wait` writes a register, and every register resets to 7.
- R4: During a read strobe `rd_n`=0 and `ad_oe`=0. `ad_in` is sampled at the clock edge that ends the strobe phase, and the result is presented on `req_rdata` together with `req_ack`.
- R5: In 16-bit mode (`bus_narrow`=0) the address is driven with bit 0 forced to 0. During a write strobe `ad_out` carries `req_wdata`, and `wr_n[i]` is 0 exactly when `req_be[i]`=1.
- R6: In 8-bit mode with `req_be`=11, two bus cycles run back to back at the even address and then the odd address. A write sends low byte then high byte on `ad_out[7:0]` with `ad_out[15:8]`=0 and only `wr_n[0]` active. `req_ack` comes only after the second cycle.
- R7: In 8-bit mode with a single enabled byte, one bus cycle runs at that byte's address (bit 0 = 1 for `req_be`=10). The byte travels on lane 0 and a read lands in the matching half of `req_rdata`.
- R8: The address strobe never overlaps any data strobe, and read and write strobes never overlap. While `req_ready`=1 the bus is quiet: no strobes and `ad_oe`=0.
- R9: A request is accepted when `req_valid` and `req_ready` are both 1. `req_ready` stays 0 until the access completes, and `req_ack` is a one-clock pulse that occurs only while `req_ready`=1.
- R10: Bytes of `req_rdata` whose byte enable is 0 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Write one area wait register |
| cfg_area | input | 2 | Area selected for the write |
| cfg_wait | input | 3 | Wait count to store |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request accepted this clock |
| req_write | input | 1 | 1 = write, 0 = read |
| bus_narrow | input | 1 | 1 = 8-bit external data, 0 = 16-bit |
| req_addr | input | 16 | Byte address |
| req_be | input | 2 | Byte enables, bit 0 = even byte |
| req_wdata | input | 16 | Write data, bits 7:0 = even byte |
| req_ack | output | 1 | One-clock completion pulse |
| req_rdata | output | 16 | Read data, valid with `req_ack` |
| ale | output | 1 | Address latch strobe, active high |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 2 | Byte-lane write strobes, active low |
| ad_out | output | 16 | Multiplexed address/data out |
| ad_oe | output | 1 | Drive enable for `ad_out` |
| ad_in | input | 16 | Data read back from the pins |

## Verification
On every clock the assertions check the mutual exclusion of the address, read and write strobes, the release of the pins during a read strobe, the one-clock width of the latch strobe and of the acknowledge, that every read strobe follows an address phase, and that the bus is quiet while idle. Only the bench's scenarios can show the strobe length for each area's wait count and the reset value of those counts. The same holds for the split order and byte placement in narrow mode, the address bit 0 rules, the zeroing of disabled read bytes and the exact clock of the acknowledge, since each of these needs the stimulus to be known.

// File: rtl/mxbus_pkg.sv
package mxbus_pkg;
    localparam int unsigned MXB_ADDR_W = 16;
    localparam int unsigned MXB_DATA_W = 16;
    localparam int unsigned MXB_WAIT_W = 3;
    localparam int unsigned MXB_AREA_W = 2;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_STRB = 2'd2
    } phase_e;
endpackage

// File: rtl/mxbus_wait_regs.sv
module mxbus_wait_regs #(
    parameter int unsigned AREA_W = 2,
    parameter int unsigned WAIT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [AREA_W-1:0] cfg_area,
    input  logic [WAIT_W-1:0] cfg_wait,
    input  logic [AREA_W-1:0] sel_area,
    output logic [WAIT_W-1:0] sel_wait
);
    localparam int unsigned AREAS = 1 << AREA_W;
    localparam logic [WAIT_W-1:0] WAIT_RST = '1;

    logic [WAIT_W-1:0] wait_d [AREAS];
    logic [WAIT_W-1:0] wait_q [AREAS];

    for (genvar g = 0; g < AREAS; g++) begin : g_area
        always_comb begin
            wait_d[g] = wait_q[g];
            if (cfg_we && (cfg_area == AREA_W'(g))) begin
                wait_d[g] = cfg_wait;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                wait_q[g] <= WAIT_RST;
            end else begin
                wait_q[g] <= wait_d[g];
            end
        end
    end

    assign sel_wait = wait_q[sel_area];
endmodule

// File: rtl/mxbus_lane.sv
module mxbus_lane #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 16
) (
    input  logic              narrow,
    input  logic              byte_hi,
    input  logic [1:0]        be,
    input  logic [ADDR_W-1:1] addr_hi,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] ad_in,
    input  logic [DATA_W-1:0] rdata_in,
    output logic [ADDR_W-1:0] beat_addr,
    output logic [DATA_W-1:0] beat_wdata,
    output logic [1:0]        beat_wen,
    output logic [DATA_W-1:0] rdata_out
);
    localparam int unsigned LANE_W = DATA_W / 2;

    logic [LANE_W-1:0] lo_in;
    logic              byte_en;

    assign lo_in   = ad_in[LANE_W-1:0];
    assign byte_en = byte_hi ? be[1] : be[0];

    always_comb begin
        rdata_out = rdata_in;
        if (narrow) begin
            beat_addr  = {addr_hi, byte_hi};
            beat_wdata = {{LANE_W{1'b0}}, (byte_hi ? wdata[DATA_W-1:LANE_W] : wdata[LANE_W-1:0])};
            beat_wen   = {1'b0, byte_en};
            if (byte_en) begin
                if (byte_hi) begin
                    rdata_out[DATA_W-1:LANE_W] = lo_in;
                end else begin
                    rdata_out[LANE_W-1:0] = lo_in;
                end
            end
        end else begin
            beat_addr  = {addr_hi, 1'b0};
            beat_wdata = wdata;
            beat_wen   = be;
            rdata_out  = {(be[1] ? ad_in[DATA_W-1:LANE_W] : {LANE_W{1'b0}}),
                          (be[0] ? lo_in : {LANE_W{1'b0}})};
        end
    end
endmodule

// File: rtl/mxbus_ctrl.sv
module mxbus_ctrl
    import mxbus_pkg::*;
#(
    parameter int unsigned ADDR_W = MXB_ADDR_W,
    parameter int unsigned DATA_W = MXB_DATA_W,
    parameter int unsigned WAIT_W = MXB_WAIT_W,
    parameter int unsigned AREA_W = MXB_AREA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [AREA_W-1:0] cfg_area,
    input  logic [WAIT_W-1:0] cfg_wait,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic              bus_narrow,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_be,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ack,
    output logic [DATA_W-1:0] req_rdata,
    output logic              ale,
    output logic              rd_n,
    output logic [1:0]        wr_n,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    input  logic [DATA_W-1:0] ad_in
);
    typedef struct packed {
        phase_e            ph;
        logic [WAIT_W-1:0] cnt;
        logic [WAIT_W-1:0] wcnt;
        logic              split;
        logic              second;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [1:0]        be;
        logic              wr;
        logic              narrow;
        logic [DATA_W-1:0] rdata;
        logic              ack;
    } ctl_t;

    ctl_t r_d, r_q;

    logic [WAIT_W-1:0] area_wait;
    logic              byte_hi;
    logic [ADDR_W-1:0] beat_addr;
    logic [DATA_W-1:0] beat_wdata;
    logic [1:0]        beat_wen;
    logic [DATA_W-1:0] rdata_mrg;
    logic              in_strb;

    mxbus_wait_regs #(
        .AREA_W (AREA_W),
        .WAIT_W (WAIT_W)
    ) i_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_area (cfg_area),
        .cfg_wait (cfg_wait),
        .sel_area (req_addr[ADDR_W-1 -: AREA_W]),
        .sel_wait (area_wait)
    );

    assign byte_hi = r_q.split ? r_q.second : (r_q.be == 2'b10);

    mxbus_lane #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) i_lane (
        .narrow     (r_q.narrow),
        .byte_hi    (byte_hi),
        .be         (r_q.be),
        .addr_hi    (r_q.addr[ADDR_W-1:1]),
        .wdata      (r_q.wdata),
        .ad_in      (ad_in),
        .rdata_in   (r_q.rdata),
        .beat_addr  (beat_addr),
        .beat_wdata (beat_wdata),
        .beat_wen   (beat_wen),
        .rdata_out  (rdata_mrg)
    );

    always_comb begin
        r_d     = r_q;
        r_d.ack = 1'b0;
        unique case (r_q.ph)
            PH_IDLE: begin
                if (req_valid) begin
                    r_d.ph     = PH_ADDR;
                    r_d.addr   = req_addr;
                    r_d.wdata  = req_wdata;
                    r_d.be     = req_be;
                    r_d.wr     = req_write;
                    r_d.narrow = bus_narrow;
                    r_d.wcnt   = area_wait;
                    r_d.split  = bus_narrow && (req_be == 2'b11);
                    r_d.second = 1'b0;
                    r_d.rdata  = '0;
                end
            end
            PH_ADDR: begin
                r_d.ph  = PH_STRB;
                r_d.cnt = r_q.wcnt;
            end
            PH_STRB: begin
                if (r_q.cnt != '0) begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end else begin
                    if (!r_q.wr) begin
                        r_d.rdata = rdata_mrg;
                    end
                    if (r_q.split && !r_q.second) begin
                        r_d.second = 1'b1;
                        r_d.ph     = PH_ADDR;
                    end else begin
                        r_d.ph  = PH_IDLE;
                        r_d.ack = 1'b1;
                    end
                end
            end
            default: r_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{ph: PH_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign in_strb   = (r_q.ph == PH_STRB);
    assign req_ready = (r_q.ph == PH_IDLE);
    assign req_ack   = r_q.ack;
    assign req_rdata = r_q.rdata;
    assign ale       = (r_q.ph == PH_ADDR);
    assign rd_n      = !(in_strb && !r_q.wr);
    assign wr_n      = ~({2{in_strb && r_q.wr}} & beat_wen);
    assign ad_oe     = ale || (in_strb && r_q.wr);
    assign ad_out    = ale ? DATA_W'(beat_addr)
                           : ((in_strb && r_q.wr) ? beat_wdata : '0);
endmodule

// File: rtl/mxbus_ctrl_chk.sv
module mxbus_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_ready,
    input logic       req_ack,
    input logic       ale,
    input logic       rd_n,
    input logic [1:0] wr_n,
    input logic       ad_oe
);
    // R8
    ale_strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (rd_n && (&wr_n)));

    // R8
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> (&wr_n));

    // R4
    rd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe);

    // R2
    ale_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);

    // R2
    rd_after_ale_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_n) |-> $past(ale));

    // R9
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |=> !req_ack);

    // R9
    ack_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |-> req_ready);

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!ale && rd_n && (&wr_n) && !ad_oe));
endmodule

bind mxbus_ctrl mxbus_ctrl_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .req_ack   (req_ack),
    .ale       (ale),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .ad_oe     (ad_oe)
);

// File: tb/test_mxbus_ctrl.sv
module test_mxbus_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_area = '0;
    logic [2:0]  cfg_wait = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic        bus_narrow = 1'b0;
    logic [15:0] req_addr = '0;
    logic [1:0]  req_be = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ack;
    logic [15:0] req_rdata;
    logic        ale;
    logic        rd_n;
    logic [1:0]  wr_n;
    logic [15:0] ad_out;
    logic        ad_oe;
    logic [15:0] ad_in;

    always #2 clk = ~clk;

    mxbus_ctrl i_mxbus_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_area(cfg_area), .cfg_wait(cfg_wait),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .bus_narrow(bus_narrow), .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
        .req_ack(req_ack), .req_rdata(req_rdata), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
        .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in)
    );

    // external memory model: byte at address a reads as a[7:0] ^ 8'h3C
    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        return a[7:0] ^ 8'h3C;
    endfunction

    logic [15:0] lat_addr = '0;
    always @(posedge clk) if (ale) lat_addr <= ad_out;
    always_comb begin
        if (bus_narrow) ad_in = {8'h00, mem_byte(lat_addr)};
        else            ad_in = {mem_byte(lat_addr | 16'h0001), mem_byte(lat_addr & 16'hFFFE)};
    end

    typedef struct packed {
        logic        w8;
        logic        wr;
        logic [1:0]  be;
        logic [15:0] addr;
        logic [15:0] wdata;
        logic [7:0]  cyc;
        logic [3:0]  nale;
        logic [7:0]  nstrb;
        logic [15:0] a0;
        logic [15:0] a1;
        logic [15:0] d0;
        logic [15:0] d1;
        logic [1:0]  wen0;
        logic [15:0] rdata;
    } vec_t;

    // waits: area0=0, area1=2, area2=5, area3 left at reset value 7
    localparam vec_t TBL [8] = '{
        '{1'b0, 1'b0, 2'b11, 16'h0010, 16'h0000, 8'd3,  4'd1, 8'd1, 16'h0010, 16'h0000, 16'h0000, 16'h0000, 2'b00, 16'h2D2C},
        '{1'b0, 1'b0, 2'b01, 16'h4020, 16'h0000, 8'd5,  4'd1, 8'd3, 16'h4020, 16'h0000, 16'h0000, 16'h0000, 2'b00, 16'h001C},
        '{1'b0, 1'b1, 2'b11, 16'h8004, 16'hBEEF, 8'd8,  4'd1, 8'd6, 16'h8004, 16'h0000, 16'hBEEF, 16'h0000, 2'b11, 16'h0000},
        '{1'b1, 1'b0, 2'b11, 16'h0031, 16'h0000, 8'd5,  4'd2, 8'd2, 16'h0030, 16'h0031, 16'h0000, 16'h0000, 2'b00, 16'h0D0C},
        '{1'b1, 1'b1, 2'b11, 16'h4042, 16'h1234, 8'd9,  4'd2, 8'd6, 16'h4042, 16'h4043, 16'h0034, 16'h0012, 2'b01, 16'h0000},
        '{1'b1, 1'b0, 2'b10, 16'hC050, 16'h0000, 8'd10, 4'd1, 8'd8, 16'hC051, 16'h0000, 16'h0000, 16'h0000, 2'b00, 16'h6D00},
        '{1'b1, 1'b1, 2'b01, 16'h8061, 16'hAA55, 8'd8,  4'd1, 8'd6, 16'h8060, 16'h0000, 16'h0055, 16'h0000, 2'b01, 16'h0000},
        '{1'b0, 1'b1, 2'b10, 16'h0071, 16'h9876, 8'd3,  4'd1, 8'd1, 16'h0070, 16'h0000, 16'h9876, 16'h0000, 2'b10, 16'h0000}
    };

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    task automatic cfg_write(input logic [1:0] area, input logic [2:0] w);
        @(negedge clk);
        cfg_we = 1'b1; cfg_area = area; cfg_wait = w;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic run_vec(input int idx, input vec_t v);
        int k = 0;
        int n_ale = 0;
        int n_strb = 0;
        int bad = 0;
        int ready_bad = 0;
        logic [15:0] a0 = '0, a1 = '0, d0 = '0, d1 = '0;
        logic [1:0] wen0 = '0;
        @(negedge clk);
        bus_narrow = v.w8; req_write = v.wr; req_be = v.be;
        req_addr = v.addr; req_wdata = v.wdata; req_valid = 1'b1;
        do begin
            @(negedge clk);
            k++;
            req_valid = 1'b0;
            if (ale) begin
                n_ale++;
                if (n_ale == 1) a0 = ad_out; else a1 = ad_out;
                if (!rd_n || !(&wr_n)) bad++;
            end
            if (!rd_n && !(&wr_n)) bad++;
            if (!rd_n && ad_oe) bad++;
            if (!rd_n || !(&wr_n)) begin
                n_strb++;
                if (ad_oe) begin
                    if (n_ale == 1) d0 = ad_out; else d1 = ad_out;
                end
                if (n_ale == 1 && !(&wr_n)) wen0 = ~wr_n;
            end
            if (req_ready && !req_ack) ready_bad++;
        end while (!req_ack && k < 60);
        check(k == int'(v.cyc), $sformatf("R2/R3 vec%0d ack clock", idx), k, v.cyc);
        check(n_ale == int'(v.nale), $sformatf("R6/R7 vec%0d bus cycles", idx), n_ale, v.nale);
        check(n_strb == int'(v.nstrb), $sformatf("R3 vec%0d strobe clocks", idx), n_strb, v.nstrb);
        check(a0 == v.a0, $sformatf("R5/R7 vec%0d first address", idx), a0, v.a0);
        if (v.nale == 4'd2) check(a1 == v.a1, $sformatf("R6 vec%0d second address", idx), a1, v.a1);
        if (v.wr) begin
            check(d0 == v.d0, $sformatf("R5/R6 vec%0d first write data", idx), d0, v.d0);
            check(wen0 == v.wen0, $sformatf("R5/R7 vec%0d write lanes", idx), wen0, v.wen0);
            if (v.nale == 4'd2) check(d1 == v.d1, $sformatf("R6 vec%0d second write data", idx), d1, v.d1);
        end else begin
            check(req_rdata == v.rdata, $sformatf("R4/R10 vec%0d read data", idx), req_rdata, v.rdata);
        end
        check(bad == 0, $sformatf("R8 vec%0d strobe overlap", idx), bad, 0);
        check(ready_bad == 0, $sformatf("R9 vec%0d ready while busy", idx), ready_bad, 0);
        @(negedge clk);
        check(!req_ack && req_ready, $sformatf("R9 vec%0d ack single clock", idx), {req_ack, req_ready}, 2'b01);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            report();
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(!ale && rd_n && (&wr_n) && !ad_oe && !req_ack && req_ready,
              "R1 outputs in reset", {ale, rd_n, wr_n, ad_oe, req_ack, req_ready}, 7'b0111001);
        rst_n = 1'b1;
        @(negedge clk);
        check(!ale && rd_n && (&wr_n) && !ad_oe && !req_ack && req_ready,
              "R1 outputs after reset", {ale, rd_n, wr_n, ad_oe, req_ack, req_ready}, 7'b0111001);

        // R3: program area wait counts, leave area 3 at its reset value
        cfg_write(2'd0, 3'd0);
        cfg_write(2'd1, 3'd2);
        cfg_write(2'd2, 3'd5);
        @(negedge clk);
        check(!ale && rd_n && !ad_oe, "R8 configuration leaves bus quiet", {ale, rd_n, ad_oe}, 3'b010);

        for (int i = 0; i < 8; i++) begin
            run_vec(i, TBL[i]);
        end

        // R3: reprogram area 0 to 7 and confirm the longer strobe
        cfg_write(2'd0, 3'd7);
        run_vec(8, '{1'b0, 1'b0, 2'b11, 16'h0010, 16'h0000, 8'd10, 4'd1, 8'd8,
                     16'h0010, 16'h0000, 16'h0000, 16'h0000, 2'b00, 16'h2D2C});

        // R10: narrow read with no byte enabled returns zero
        cfg_write(2'd0, 3'd0);
        run_vec(9, '{1'b1, 1'b0, 2'b00, 16'h0044, 16'h0000, 8'd3, 4'd1, 8'd1,
                     16'h0044, 16'h0000, 16'h0000, 16'h0000, 2'b00, 16'h0000});

        done = 1'b1;
        report();
    end
endmodule